// File: doc/BRIEF.md
# NAND Address Cycle Generator

This block converts a column offset and a page (row) number into the ordered byte stream that a NAND device expects during its address phase. A controller pulses `start` with both addresses, a flag for each that marks it as absent, a page-size mode and a page mask. The block then presents one address byte at a time on a valid/ready output. Column bytes come first and row bytes follow. One clock after the last byte is taken, `done` pulses.

The page-size mode sets how many column bytes go out and how the upper column byte is trimmed. The page mask sets how many row bytes are needed: after each row byte, the mask is shifted right by eight bits, and row bytes continue until the shifted mask is zero. An absent column or an absent page removes its whole group of cycles. A block erase, for example, sends only row bytes. If both are absent, the block sends nothing and pulses `done`. Pin timing, command latching and data transfer belong to neighbouring blocks.

Top module: `nag_addr_gen`

## Requirements
- R1: After reset, `out_valid`, `done` and `busy` are all low.
- R2: When the column is present, the first byte sent is `col_addr[7:0]`.
- R3: With `page_mode` = 1 (2K pages), a second column byte follows that carries `col_addr[11:8]` in bits [3:0], with bits [7:4] zero.
- R4: With `page_mode` = 2 (4K pages), a second column byte follows that carries `col_addr[12:8]` in bits [4:0], with bits [7:5] zero.
- R5: With `page_mode` = 0 (512-byte pages), exactly one column byte is sent. Code 3 behaves the same as code 0.
- R6: When the page is present, row byte k (k from 0) is `row_addr[8k+7:8k]`. The number of row bytes is the index of the highest nonzero byte of `row_mask` plus one, and is at least one, so a zero mask still sends one row byte.
- R7: `col_skip` = 1 removes all column bytes, and `row_skip` = 1 removes all row bytes. All column bytes go out before any row byte.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `done` is high for exactly one cycle, in the cycle after the final byte is accepted. If both addresses are absent, `done` goes high in the cycle after `start` and no byte is sent.
- R10: A `start` pulse that arrives while `busy` is high is ignored. The byte sequence in progress is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Captures the inputs when idle |
| col_addr | input | COL_W | Column offset |
| col_skip | input | 1 | Column absent |
| row_addr | input | ROW_W | Page number |
| row_skip | input | 1 | Page absent |
| row_mask | input | ROW_W | Page mask, sets the row byte count |
| page_mode | input | 2 | 0: 512, 1: 2K, 2: 4K, 3: as 512 |
| out_valid | output | 1 | Address byte available |
| out_ready | input | 1 | Receiver takes the byte |
| out_data | output | 8 | Address byte |
| done | output | 1 | One-cycle end pulse |
| busy | output | 1 | A sequence is in progress |

## Verification
The bench targets the following corner cases, each paired with the fault it exposes:
- A zero page mask must still send one row byte. A loop that tests the mask before sending would send none.
- A mask whose only set bit lies in the top byte must send four row bytes.
- The second column byte is checked with all upper column bits set. A wrong trim constant for 2K or 4K mode would let stray bits through.
- A request with both addresses absent must pulse `done` with no byte sent. A design that got this wrong would hang or emit a stray byte.
- Long stalls on `out_ready` must leave the presented byte unchanged. A design that advanced early would drop a byte.
- A second `start` in the middle of a sequence must not change the bytes. A design that recaptured its inputs would corrupt the stream.

// File: rtl/nag_pkg.sv
package nag_pkg;
  typedef enum logic [1:0] {
    PG_512  = 2'd0,
    PG_2K   = 2'd1,
    PG_4K   = 2'd2,
    PG_RSVD = 2'd3
  } pg_mode_e;

  localparam int unsigned BYTE_W = 8;

  // Number of column cycles for a given mode when the column is present.
  function automatic logic [1:0] col_cycles(input logic [1:0] mode);
    case (mode)
      PG_2K, PG_4K: col_cycles = 2'd2;
      default:      col_cycles = 2'd1;
    endcase
  endfunction

  // Mask applied to the upper column byte.
  function automatic logic [7:0] col_hi_mask(input logic [1:0] mode);
    case (mode)
      PG_2K:   col_hi_mask = 8'h0F;
      PG_4K:   col_hi_mask = 8'h1F;
      default: col_hi_mask = 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/nag_row_count.sv
module nag_row_count #(
  parameter int unsigned ROW_W = 32,
  localparam int unsigned NB    = ROW_W / 8,
  localparam int unsigned CNT_W = $clog2(NB + 1)
) (
  input  logic [ROW_W-1:0] mask,
  output logic [CNT_W-1:0] cnt
);
  logic [NB-1:0] byte_nz;

  genvar gi;
  generate
    for (gi = 0; gi < NB; gi++) begin : g_nz
      assign byte_nz[gi] = |mask[8*gi +: 8];
    end
  endgenerate

  always_comb begin
    cnt = CNT_W'(1);
    for (int i = 0; i < NB; i++) begin
      if (byte_nz[i]) cnt = CNT_W'(i + 1);
    end
  end

  always_comb begin
    AST_ROW_CNT_RANGE: assert (cnt >= CNT_W'(1) && cnt <= CNT_W'(NB)); // R6
  end
endmodule

// File: rtl/nag_byte_sel.sv
module nag_byte_sel
  import nag_pkg::*;
#(
  parameter int unsigned COL_W = 16,
  parameter int unsigned ROW_W = 32,
  parameter int unsigned IDX_W = 3
) (
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  input  logic [1:0]       mode,
  input  logic [IDX_W-1:0] col_cnt,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  logic [IDX_W-1:0] ridx;
  logic [7:0]       col_lo, col_hi, row_b;

  assign ridx   = idx - col_cnt;
  assign col_lo = col[7:0];
  assign col_hi = 8'(col >> 8) & col_hi_mask(mode);
  assign row_b  = 8'(row >> (8 * ridx));

  always_comb begin
    if (idx < col_cnt) begin
      byte_o = (idx == '0) ? col_lo : col_hi;
    end else begin
      byte_o = row_b;
    end
  end
endmodule

// File: rtl/nag_addr_gen.sv
module nag_addr_gen
  import nag_pkg::*;
#(
  parameter int unsigned COL_W = 16,
  parameter int unsigned ROW_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] col_addr,
  input  logic             col_skip,
  input  logic [ROW_W-1:0] row_addr,
  input  logic             row_skip,
  input  logic [ROW_W-1:0] row_mask,
  input  logic [1:0]       page_mode,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [7:0]       out_data,
  output logic             done,
  output logic             busy
);
  localparam int unsigned NB    = ROW_W / 8;
  localparam int unsigned CNT_W = $clog2(NB + 1);
  localparam int unsigned MAXT  = NB + 2;
  localparam int unsigned IDX_W = $clog2(MAXT + 1);

  // Captured request
  logic [COL_W-1:0] col_q;
  logic [ROW_W-1:0] row_q;
  logic [1:0]       mode_q;
  logic [IDX_W-1:0] col_cnt_q, total_q, idx_q;
  logic             busy_q, valid_q, done_q;
  logic [7:0]       data_q;

  // Plan for the incoming request
  logic [CNT_W-1:0] row_cnt_raw;
  logic [IDX_W-1:0] col_cnt_in, row_cnt_in, total_in;
  logic [7:0]       first_byte, next_byte;
  logic [IDX_W-1:0] idx_next;
  logic             accept, last_beat;

  nag_row_count #(.ROW_W(ROW_W)) u_rcnt (
    .mask (row_mask),
    .cnt  (row_cnt_raw)
  );

  assign col_cnt_in = col_skip ? '0 : IDX_W'(col_cycles(page_mode));
  assign row_cnt_in = row_skip ? '0 : IDX_W'(row_cnt_raw);
  assign total_in   = col_cnt_in + row_cnt_in;

  nag_byte_sel #(.COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_sel_first (
    .col     (col_addr),
    .row     (row_addr),
    .mode    (page_mode),
    .col_cnt (col_cnt_in),
    .idx     ('0),
    .byte_o  (first_byte)
  );

  assign idx_next = idx_q + IDX_W'(1);

  nag_byte_sel #(.COL_W(COL_W), .ROW_W(ROW_W), .IDX_W(IDX_W)) u_sel_next (
    .col     (col_q),
    .row     (row_q),
    .mode    (mode_q),
    .col_cnt (col_cnt_q),
    .idx     (idx_next),
    .byte_o  (next_byte)
  );

  assign accept    = valid_q && out_ready;
  assign last_beat = (idx_next == total_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      col_q     <= '0;
      row_q     <= '0;
      mode_q    <= PG_512;
      col_cnt_q <= '0;
      total_q   <= '0;
      idx_q     <= '0;
      busy_q    <= 1'b0;
      valid_q   <= 1'b0;
      done_q    <= 1'b0;
      data_q    <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start) begin
          col_q     <= col_addr;
          row_q     <= row_addr;
          mode_q    <= page_mode;
          col_cnt_q <= col_cnt_in;
          total_q   <= total_in;
          idx_q     <= '0;
          if (total_in == '0) begin
            done_q <= 1'b1;
          end else begin
            busy_q  <= 1'b1;
            valid_q <= 1'b1;
            data_q  <= first_byte;
          end
        end
      end else if (accept) begin
        if (last_beat) begin
          valid_q <= 1'b0;
          busy_q  <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          idx_q  <= idx_next;
          data_q <= next_byte;
        end
      end
    end
  end

  assign out_valid = valid_q;
  assign out_data  = data_q;
  assign done      = done_q;
  assign busy      = busy_q;

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> (!out_valid && !busy)); // R9
  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(col_q) && $stable(row_q) && $stable(total_q))); // R10
  AST_COL_HI_4K: assert property (@(posedge clk) disable iff (rst)
    (out_valid && idx_q == IDX_W'(1) && col_cnt_q == IDX_W'(2) && mode_q == PG_4K)
      |-> (out_data[7:5] == 3'b000)); // R4
  AST_COL_HI_2K: assert property (@(posedge clk) disable iff (rst)
    (out_valid && idx_q == IDX_W'(1) && col_cnt_q == IDX_W'(2) && mode_q == PG_2K)
      |-> (out_data[7:4] == 4'b0000)); // R3
endmodule

// File: tb/nag_addr_gen_tb.sv
module nag_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] col_addr = '0;
  logic        col_skip = 1'b0;
  logic [31:0] row_addr = '0;
  logic        row_skip = 1'b0;
  logic [31:0] row_mask = '0;
  logic [1:0]  page_mode = '0;
  logic        out_ready = 1'b0;
  logic        out_valid, done, busy;
  logic [7:0]  out_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nag_addr_gen dut_i (
    .clk(clk), .rst(rst), .start(start),
    .col_addr(col_addr), .col_skip(col_skip),
    .row_addr(row_addr), .row_skip(row_skip),
    .row_mask(row_mask), .page_mode(page_mode),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .done(done), .busy(busy)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Expected byte list from the requirements
  function automatic int model(input int mode, input int col, input bit cs,
                               input int unsigned page, input bit ps,
                               input int unsigned mask, output int eb[8],
                               output string et[8]);
    int n = 0;
    int unsigned p = page, m = mask;
    if (!cs) begin
      eb[n] = col & 8'hFF; et[n] = "R2"; n++;
      if (mode == 1) begin eb[n] = (col >> 8) & 8'h0F; et[n] = "R3"; n++; end
      if (mode == 2) begin eb[n] = (col >> 8) & 8'h1F; et[n] = "R4"; n++; end
    end
    if (!ps) begin
      do begin
        eb[n] = int'(p & 32'hFF); et[n] = "R6"; n++;
        p = p >> 8; m = m >> 8;
      end while (m != 0);
    end
    return n;
  endfunction

  task automatic run_case(input int mode, input int col, input bit cs,
                          input int unsigned page, input bit ps,
                          input int unsigned mask, input int rdy_pct,
                          input bit disturb, input string cnt_tag);
    int eb[8];
    string et[8];
    int ecnt, n, t;
    bit prev_stall;
    logic [7:0] prev_data;
    ecnt = model(mode, col, cs, page, ps, mask, eb, et);
    @(negedge clk);
    page_mode = 2'(mode); col_addr = 16'(col); col_skip = cs;
    row_addr = page; row_skip = ps; row_mask = mask; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    col_addr = ~col_addr; row_addr = ~row_addr; row_mask = ~row_mask;
    n = 0; prev_stall = 0; prev_data = '0;
    for (t = 0; t < 400; t++) begin
      if (done) break;
      if (prev_stall)
        chk(out_valid && out_data == prev_data, "R8", int'(out_data), int'(prev_data));
      if (disturb && t == 1) begin
        start = 1'b1; col_skip = 1'b1; row_skip = 1'b1;
      end else begin
        start = 1'b0;
      end
      out_ready = (($urandom % 100) < rdy_pct);
      if (out_valid && out_ready) begin
        if (n < ecnt)
          chk(out_data == 8'(eb[n]), et[n], int'(out_data), eb[n]);
        else
          chk(0, "R7", n + 1, ecnt);
        n++;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      @(negedge clk);
    end
    start = 1'b0; out_ready = 1'b0;
    chk(done == 1'b1, "R9", int'(done), 1);
    chk(n == ecnt, cnt_tag, n, ecnt);
    if (disturb) chk(n == ecnt, "R10", n, ecnt);
    @(negedge clk);
    chk(done == 1'b0, "R9", int'(done), 0);
  endtask

  initial begin
    void'($urandom(32'h1234ABCD));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!out_valid && !done && !busy, "R1", {out_valid, done, busy}, 0);
    // Directed corner cases
    run_case(0, 16'hFFFF, 0, 32'h00000055, 0, 32'h0,        100, 0, "R5");
    run_case(3, 16'h1234, 0, 32'h11223344, 0, 32'h00FF,     100, 0, "R5");
    run_case(1, 16'hFFFF, 0, 32'hA1B2C3D4, 0, 32'h0001FFFF, 60,  0, "R3");
    run_case(2, 16'hFFFF, 0, 32'hA1B2C3D4, 0, 32'h80000000, 40,  0, "R4");
    run_case(2, 16'h0ABC, 1, 32'h00C0FFEE, 0, 32'h00FFFFFF, 100, 0, "R7");
    run_case(1, 16'h0ABC, 0, 32'h00C0FFEE, 1, 32'h00FFFFFF, 100, 0, "R7");
    run_case(1, 16'h0ABC, 1, 32'h00C0FFEE, 1, 32'hFFFFFFFF, 100, 0, "R9");
    run_case(0, 16'h0000, 0, 32'h0,        0, 32'h0,        100, 0, "R6");
    run_case(2, 16'h1FFF, 0, 32'h87654321, 0, 32'hFFFFFFFF, 30,  1, "R10");
    // Constrained random
    for (int i = 0; i < 150; i++) begin
      int unsigned mk;
      case ($urandom % 5)
        0: mk = 0;
        1: mk = $urandom & 32'hFF;
        2: mk = $urandom & 32'hFFFF;
        3: mk = $urandom & 32'hFFFFFF;
        default: mk = $urandom;
      endcase
      run_case(int'($urandom % 4), int'($urandom & 16'hFFFF), ($urandom % 6) == 0,
               $urandom, ($urandom % 6) == 0, mk, 30 + int'($urandom % 71),
               ($urandom % 8) == 0, "R6");
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule